// File: doc/BRIEF.md
# Control-Line Interrupt Flag Unit

This unit holds the interrupt flags for the four handshake control inputs of a parallel-port adapter, two per port (port A lines A1 and A2, port B lines B1 and B2), plus one flag for shift-register completion. Each control input is brought into the clock domain through a two-flop synchroniser. It is then compared with the level it had one cycle earlier. The active direction of each line is chosen by the peripheral control value `pcr_i`, which is owned by the surrounding register file. A transition in the chosen direction sets a sticky flag. The flag stays set until software clears it.

Flags are cleared in two ways. The port data access strobes clear them as the port protocol requires. A write to the flag register clears each flag whose bit is written as one. An enable register masks the flags onto a single active-low interrupt output. The flag read value carries a summary bit that shows whether any enabled flag is pending.

Top module: `ctl_irq_flags`

## Requirements
- R1: After reset, `ifr_o` is 8'h00, `ier_o` is 8'h80 and `irq_no` is high.
- R2: Lines A1 and B1 use `pcr_i[0]` and `pcr_i[4]` respectively, where 1 selects the rising edge and 0 selects the falling edge. An active edge sets flag bit 1 (A1) or bit 4 (B1). The flag becomes visible after the third rising clock edge following the input change: two synchroniser stages, then the flag register.
- R3: Lines A2 and B2 take their edge select from `pcr_i[2]` and `pcr_i[6]` respectively, where 1 selects rising and 0 selects falling. An active edge sets flag bit 0 (A2) or bit 3 (B2), with the same latency as R2.
- R4: A flag is never set by a steady level or by a transition in the non-selected direction. Once set, a flag stays set until it is cleared.
- R5: Each cycle in which `sr_done_i` is high sets flag bit 2 at the next clock edge. No edge qualification applies to this input.
- R6: A one-cycle `porta_acc_i` clears bit 1. It also clears bit 0, unless `pcr_i[1]` is 1, which selects independent mode for A2. `portb_acc_i` applies the same rule to bits 4 and 3, with `pcr_i[5]` as the independent bit for B2.
- R7: `ifr_we_i` clears each flag whose bit in `wdata_i[4:0]` is 1. `wdata_i[7]` has no effect.
- R8: When a set condition and a clear request reach the same flag in the same cycle, the flag ends up set.
- R9: `ier_we_i` with `wdata_i[7]`=1 sets the enable bits written as 1. With `wdata_i[7]`=0 it clears those bits. `ier_o` reads as {1, 2'b00, enables[4:0]}.
- R10: `ifr_o[7]` is 1 and `irq_no` is low exactly while some flag and its enable bit are both 1. Both follow a flag or enable change with no added cycle. Bits 6:5 of `ifr_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ca1_i | input | 1 | Port A control line 1 (asynchronous) |
| ca2_i | input | 1 | Port A control line 2 (asynchronous) |
| cb1_i | input | 1 | Port B control line 1 (asynchronous) |
| cb2_i | input | 1 | Port B control line 2 (asynchronous) |
| sr_done_i | input | 1 | Shift-register completion strobe (synchronous) |
| pcr_i | input | 8 | Peripheral control value |
| porta_acc_i | input | 1 | Port A data read or write strobe |
| portb_acc_i | input | 1 | Port B data read or write strobe |
| ifr_we_i | input | 1 | Flag register write strobe |
| ier_we_i | input | 1 | Enable register write strobe |
| wdata_i | input | 8 | Write data for flag and enable registers |
| ifr_o | output | 8 | Flag register read value |
| ier_o | output | 8 | Enable register read value |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
A control-line change is due in `ifr_o` three rising edges after it is applied. Strobes and register writes take effect one edge later. `irq_no` and `ifr_o[7]` follow in the same cycle as the flag or enable change. The bench drives every stimulus on a falling clock edge. After a line change it waits four falling edges before it samples, which is one edge of margin that a sticky flag tolerates. After a strobe or write it samples on the next falling edge. A line moved in its non-selected direction is held for the same window, and the bench then confirms that the flag is still clear.

// File: rtl/ctl_irq_pkg.sv
package ctl_irq_pkg;
  localparam int DATA_W    = 8;
  localparam int FLAG_W    = 5;
  localparam int NUM_LINES = 4;
  localparam int SYNC_W    = 2;
  // flag bit positions
  localparam int F_A2 = 0;
  localparam int F_A1 = 1;
  localparam int F_SR = 2;
  localparam int F_B2 = 3;
  localparam int F_B1 = 4;
  // control value bit positions
  localparam int P_A1_POS = 0;
  localparam int P_A2_IND = 1;
  localparam int P_A2_POS = 2;
  localparam int P_B1_POS = 4;
  localparam int P_B2_IND = 5;
  localparam int P_B2_POS = 6;
endpackage

// File: rtl/ctl_irq_edge.sv
module ctl_irq_edge #(
  parameter int SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic pos_sel_i,
  output logic hit_o
);
  logic [SYNC_W-1:0] sync_q;
  logic              prev_q;
  logic              lvl;
  logic              rise, fall;

  assign lvl = sync_q[SYNC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_W-2:0], line_i};
      prev_q <= lvl;
    end
  end

  assign rise  = lvl & ~prev_q;
  assign fall  = ~lvl & prev_q;
  assign hit_o = pos_sel_i ? rise : fall;

  AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (lvl != prev_q)) else $error("hit without level change"); // R4
endmodule

// File: rtl/ctl_irq_flag_bank.sv
module ctl_irq_flag_bank #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;  // set wins
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_o[i]) else $error("set lost"); // R8
    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flags_o[i]) else $error("clear lost"); // R7
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[i] && !clr_i[i]) |=> flags_o[i]) else $error("flag dropped"); // R4
  end
endmodule

// File: rtl/ctl_irq_enable.sv
module ctl_irq_enable #(
  parameter int W      = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [W-1:0]      en_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] sel;

  assign sel = wdata_i[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  en_q <= '0;
    else if (we_i) begin
      if (wdata_i[DATA_W-1])      en_q <= en_q | sel;
      else                        en_q <= en_q & ~sel;
    end
  end

  assign en_o = en_q;

  AST_IER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[DATA_W-1]) |=> ((en_o & $past(sel)) == $past(sel)))
    else $error("enable not set"); // R9
  AST_IER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[DATA_W-1]) |=> ((en_o & $past(sel)) == '0))
    else $error("enable not cleared"); // R9
endmodule

// File: rtl/ctl_irq_flags.sv
module ctl_irq_flags
  import ctl_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ca1_i,
  input  logic              ca2_i,
  input  logic              cb1_i,
  input  logic              cb2_i,
  input  logic              sr_done_i,
  input  logic [DATA_W-1:0] pcr_i,
  input  logic              porta_acc_i,
  input  logic              portb_acc_i,
  input  logic              ifr_we_i,
  input  logic              ier_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ifr_o,
  output logic [DATA_W-1:0] ier_o,
  output logic              irq_no
);
  localparam int PAD_W = DATA_W - 1 - FLAG_W;

  // line order: A1, A2, B1, B2
  logic [NUM_LINES-1:0] line, pos_sel, hit;
  logic [FLAG_W-1:0]    set, clr, flags, en;
  logic                 pend;

  assign line    = {cb2_i, cb1_i, ca2_i, ca1_i};
  assign pos_sel = {pcr_i[P_B2_POS], pcr_i[P_B1_POS], pcr_i[P_A2_POS], pcr_i[P_A1_POS]};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    ctl_irq_edge #(.SYNC_W(SYNC_W)) u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .line_i    (line[i]),
      .pos_sel_i (pos_sel[i]),
      .hit_o     (hit[i])
    );
  end

  always_comb begin
    set       = '0;
    set[F_A1] = hit[0];
    set[F_A2] = hit[1];
    set[F_B1] = hit[2];
    set[F_B2] = hit[3];
    set[F_SR] = sr_done_i;

    clr = ifr_we_i ? wdata_i[FLAG_W-1:0] : '0;
    if (porta_acc_i) begin
      clr[F_A1] = 1'b1;
      if (!pcr_i[P_A2_IND]) clr[F_A2] = 1'b1;
    end
    if (portb_acc_i) begin
      clr[F_B1] = 1'b1;
      if (!pcr_i[P_B2_IND]) clr[F_B2] = 1'b1;
    end
  end

  ctl_irq_flag_bank #(.W(FLAG_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set),
    .clr_i   (clr),
    .flags_o (flags)
  );

  ctl_irq_enable #(.W(FLAG_W), .DATA_W(DATA_W)) u_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ier_we_i),
    .wdata_i (wdata_i),
    .en_o    (en)
  );

  assign pend   = |(flags & en);
  assign ifr_o  = {pend, {PAD_W{1'b0}}, flags};
  assign ier_o  = {1'b1, {PAD_W{1'b0}}, en};
  assign irq_no = ~pend;

  AST_A1_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ifr_o[F_A1]) |-> $past(hit[0])) else $error("A1 flag w/o edge"); // R2
  AST_B2_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ifr_o[F_B2]) |-> $past(hit[3])) else $error("B2 flag w/o edge"); // R3
  AST_SR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_done_i |=> ifr_o[F_SR]) else $error("sr strobe lost"); // R5
  AST_PORTA_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (porta_acc_i && !hit[0]) |=> !ifr_o[F_A1]) else $error("A1 not cleared"); // R6
  AST_A2_IND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (porta_acc_i && pcr_i[P_A2_IND] && ifr_o[F_A2] && !(ifr_we_i && wdata_i[F_A2]))
      |=> ifr_o[F_A2]) else $error("A2 independent flag lost"); // R6
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifr_o[FLAG_W-1:0] == '0) |-> irq_no) else $error("irq with no flag"); // R10
endmodule

// File: tb/ctl_irq_flags_tb.sv
module ctl_irq_flags_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ca1_i = 0, ca2_i = 0, cb1_i = 0, cb2_i = 0, sr_done_i = 0;
  logic [7:0] pcr_i = 8'h00;
  logic       porta_acc_i = 0, portb_acc_i = 0, ifr_we_i = 0, ier_we_i = 0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] ifr_o, ier_o;
  logic       irq_no;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  ctl_irq_flags u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ca1_i(ca1_i), .ca2_i(ca2_i), .cb1_i(cb1_i), .cb2_i(cb2_i),
    .sr_done_i(sr_done_i), .pcr_i(pcr_i),
    .porta_acc_i(porta_acc_i), .portb_acc_i(portb_acc_i),
    .ifr_we_i(ifr_we_i), .ier_we_i(ier_we_i), .wdata_i(wdata_i),
    .ifr_o(ifr_o), .ier_o(ier_o), .irq_no(irq_no)
  );

  // {pcr, lines {B2,B1,A2,A1}, expected flags[4:0]}
  localparam logic [16:0] VEC [7] = '{
    {8'h00, 4'b0000, 5'b00000},  // R4 steady level
    {8'h00, 4'b0001, 5'b00000},  // R4 A1 rise, falling selected
    {8'h00, 4'b0000, 5'b00010},  // R2 A1 fall sets bit1
    {8'h04, 4'b0010, 5'b00011},  // R3 A2 rise sets bit0
    {8'h11, 4'b0110, 5'b10011},  // R2 B1 rise sets bit4
    {8'h11, 4'b1110, 5'b10011},  // R4 B2 rise, falling selected
    {8'h11, 4'b0110, 5'b11011}   // R3 B2 fall sets bit3
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ifr(input logic [7:0] d);
    ifr_we_i = 1; wdata_i = d; tick(1); ifr_we_i = 0; wdata_i = 0;
  endtask

  task automatic wr_ier(input logic [7:0] d);
    ier_we_i = 1; wdata_i = d; tick(1); ier_we_i = 0; wdata_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(2);
    // R1 reset state
    check("R1 ifr", ifr_o, 8'h00);
    check("R1 ier", ier_o, 8'h80);
    check("R1 irq", {7'd0, irq_no}, 8'h01);
    rst_ni = 1'b1;
    tick(2);
    check("R1 ifr after release", ifr_o, 8'h00);

    for (int i = 0; i < 7; i++) begin
      pcr_i = VEC[i][16:9];
      {cb2_i, cb1_i, ca2_i, ca1_i} = VEC[i][8:5];
      tick(4);
      check($sformatf("R2/R3/R4 vec %0d", i), {3'b000, ifr_o[4:0]}, {3'b000, VEC[i][4:0]});
    end

    // flags now 11011; R7 bit7 ignored, only bit0 cleared
    wr_ifr(8'h81);
    check("R7 partial clear", ifr_o, 8'h1A);

    // R9/R10 enable A1
    wr_ier(8'h82);
    check("R9 ier set", ier_o, 8'h82);
    check("R10 ifr summary", ifr_o, 8'h9A);
    check("R10 irq low", {7'd0, irq_no}, 8'h00);
    wr_ier(8'h02);
    check("R9 ier clear", ier_o, 8'h80);
    check("R10 irq high", {7'd0, irq_no}, 8'h01);

    // A2 falls with falling selected -> bit0 set
    ca2_i = 0; tick(4);
    check("R3 A2 fall", ifr_o, 8'h1B);

    // R6 A2 independent survives port A access
    pcr_i = 8'h13;
    porta_acc_i = 1; tick(1); porta_acc_i = 0;
    check("R6 porta indep", ifr_o, 8'h19);
    pcr_i = 8'h11;
    porta_acc_i = 1; tick(1); porta_acc_i = 0;
    check("R6 porta normal", ifr_o, 8'h18);
    pcr_i = 8'h31;
    portb_acc_i = 1; tick(1); portb_acc_i = 0;
    check("R6 portb indep", ifr_o, 8'h08);
    pcr_i = 8'h11;
    portb_acc_i = 1; tick(1); portb_acc_i = 0;
    check("R6 portb normal", ifr_o, 8'h00);

    // R5 shift-register strobe, each pulse sets
    sr_done_i = 1; tick(1); sr_done_i = 0;
    check("R5 first pulse", ifr_o, 8'h04);
    wr_ifr(8'h04);
    check("R7 sr clear", ifr_o, 8'h00);
    sr_done_i = 1; tick(1); sr_done_i = 0;
    check("R5 second pulse", ifr_o, 8'h04);

    // R8 set beats clear in same cycle
    wr_ifr(8'h04);
    sr_done_i = 1; ifr_we_i = 1; wdata_i = 8'h04;
    tick(1);
    sr_done_i = 0; ifr_we_i = 0; wdata_i = 0;
    check("R8 set wins", ifr_o, 8'h04);

    // R10 enable after flag present
    wr_ier(8'h84);
    check("R10 late enable", ifr_o, 8'h84);
    check("R10 irq late", {7'd0, irq_no}, 8'h00);
    wr_ifr(8'hFF);
    check("R10 irq released", {7'd0, irq_no}, 8'h01);

    finish_run();
  end
endmodule